// File: doc/BRIEF.md
# DMA Indexed Address Generator

This block keeps the source and destination addresses of one DMA channel and advances both after every 16-bit transfer. Each advance adds a signed step taken from one of four index registers. Two of them are element steps and two are frame steps, arranged as set 0 and set 1. Two separate select bits decide which set the source uses and which set the destination uses. The frame step of the selected set is added only on the transfer that closes a frame. Every other transfer adds the element step. A single-frame block follows the same rule.

The block receives three inputs from outside. The channel sequencer sends a transfer-done strobe. The counter block sends a last-element-of-frame flag. A double-word flag marks 32-bit elements, and each of these moves as two 16-bit transfers. In double-word mode the addresses advance after each half. The first half always adds the element step. Only the second half of a frame's final element adds the frame step.

Software loads the addresses, the four index values and the two selects through a single configuration load strobe. The load is accepted only in a cycle with no transfer strobe.

Top module: `dma_index_agen`

## Requirements
- R1: After reset both addresses read 0. All four index values and both selects are 0, and the double-word phase is the first half.
- R2: When cfg_load is high and xfer_done is low, the addresses, the four index values and both selects are taken from the cfg inputs at that edge. When cfg_load and xfer_done are high together, the load is ignored and the transfer update takes place.
- R3: With xfer_done and cfg_load both low, both addresses hold their value.
- R4: On a single-word transfer with last_elem low, each address adds the element index of its own set. Select value 0 picks set 0 and value 1 picks set 1.
- R5: On a single-word transfer with last_elem high, each address adds the frame index of its own set.
- R6: Index values are 16-bit two's complement and are added modulo 2^16, so addresses wrap in both directions.
- R7: In double-word mode, the first strobe of each pair adds the element index even when last_elem is high.
- R8: In double-word mode, the second strobe of a pair adds the frame index when last_elem is high and the element index when it is low.
- R9: The pair phase flips on every strobe taken in double-word mode. It returns to the first half in any cycle where dword_mode is low and on an accepted configuration load.
- R10: The source and destination set selects act independently. Each address uses only its own set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Configuration load strobe, accepted only without xfer_done |
| cfg_src_addr | input | 16 | Source address to load |
| cfg_dst_addr | input | 16 | Destination address to load |
| cfg_elem_idx0 | input | 16 | Element step of set 0 |
| cfg_elem_idx1 | input | 16 | Element step of set 1 |
| cfg_frame_idx0 | input | 16 | Frame step of set 0 |
| cfg_frame_idx1 | input | 16 | Frame step of set 1 |
| cfg_src_sel | input | 1 | Index set for the source (0 or 1) |
| cfg_dst_sel | input | 1 | Index set for the destination (0 or 1) |
| xfer_done | input | 1 | One 16-bit transfer completed |
| last_elem | input | 1 | The current element is the last in its frame |
| dword_mode | input | 1 | Elements are 32-bit and move as two halves |
| src_addr | output | 16 | Current source address |
| dst_addr | output | 16 | Current destination address |

## Verification
Both addresses are registered. A strobe or load seen at one rising edge therefore shows at the outputs right after that edge, with no extra latency. The bench changes the inputs on the falling edge and samples the outputs at the following falling edge, which is half a cycle after the edge that updates them. The double-word phase is one register, so the step it selects applies to the strobe that arrives at the edge after the previous flip. The directed cases are built so that each phase reset is followed at once by a strobe whose result exposes the phase.

// File: rtl/dma_idx_pkg.sv
`timescale 1ns/1ps
package dma_idx_pkg;
  localparam int ADDR_W = 16;

  typedef enum logic { STEP_ELEM = 1'b0, STEP_FRAME = 1'b1 } step_kind_e;

  // Frame step only on a closing transfer; in pair mode only on the second half
  function automatic step_kind_e pick_kind(logic last, logic dword, logic second);
    if (last && (!dword || second)) return STEP_FRAME;
    return STEP_ELEM;
  endfunction
endpackage

// File: rtl/dma_idx_regfile.sv
`timescale 1ns/1ps
module dma_idx_regfile #(
  parameter int AW = 16,
  parameter int NSET = 2,
  localparam int SW = $clog2(NSET)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic [NSET-1:0][AW-1:0]  elem_in,
  input  logic [NSET-1:0][AW-1:0]  frame_in,
  input  logic [SW-1:0]            src_sel_in,
  input  logic [SW-1:0]            dst_sel_in,
  output logic [NSET-1:0][AW-1:0]  elem_q,
  output logic [NSET-1:0][AW-1:0]  frame_q,
  output logic [SW-1:0]            src_sel_q,
  output logic [SW-1:0]            dst_sel_q
);
  for (genvar s = 0; s < NSET; s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        elem_q[s]  <= '0;
        frame_q[s] <= '0;
      end else if (load_en) begin
        elem_q[s]  <= elem_in[s];
        frame_q[s] <= frame_in[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel_q <= '0;
      dst_sel_q <= '0;
    end else if (load_en) begin
      src_sel_q <= src_sel_in;
      dst_sel_q <= dst_sel_in;
    end
  end
endmodule

// File: rtl/dma_dw_phase.sv
`timescale 1ns/1ps
module dma_dw_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic dword_mode,
  input  logic xfer_done,
  output logic second_half
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    second_half <= 1'b0;
    else if (clear || !dword_mode) second_half <= 1'b0;
    else if (xfer_done)            second_half <= ~second_half;
  end

  // R9
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dword_mode && xfer_done && !clear) |=> (second_half != $past(second_half)));
  // R9
  phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dword_mode || clear) |=> !second_half);
endmodule

// File: rtl/dma_step_sel.sv
`timescale 1ns/1ps
module dma_step_sel
  import dma_idx_pkg::*;
#(
  parameter int AW = 16,
  parameter int NSET = 2,
  localparam int SW = $clog2(NSET)
) (
  input  logic [SW-1:0]           set_sel,
  input  step_kind_e              kind,
  input  logic [NSET-1:0][AW-1:0] elem_idx,
  input  logic [NSET-1:0][AW-1:0] frame_idx,
  output logic [AW-1:0]           step
);
  always_comb begin
    if (kind == STEP_FRAME) step = frame_idx[set_sel];
    else                    step = elem_idx[set_sel];
  end
endmodule

// File: rtl/dma_addr_reg.sv
`timescale 1ns/1ps
module dma_addr_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  input  logic [AW-1:0] step,
  output logic [AW-1:0] addr
);
  // Two's complement step, result truncated to the address width
  function automatic logic [AW-1:0] next_addr(logic [AW-1:0] a, logic [AW-1:0] s);
    return a + s;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (adv)     addr <= next_addr(addr, step);
    else if (load_en) addr <= load_val;
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load_en) |=> $stable(addr));
  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !adv) |=> (addr == $past(load_val)));
endmodule

// File: rtl/dma_index_agen.sv
`timescale 1ns/1ps
module dma_index_agen
  import dma_idx_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [AW-1:0] cfg_elem_idx0,
  input  logic [AW-1:0] cfg_elem_idx1,
  input  logic [AW-1:0] cfg_frame_idx0,
  input  logic [AW-1:0] cfg_frame_idx1,
  input  logic          cfg_src_sel,
  input  logic          cfg_dst_sel,
  input  logic          xfer_done,
  input  logic          last_elem,
  input  logic          dword_mode,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr
);
  localparam int NSET  = 2;
  localparam int NSIDE = 2;   // 0 = source, 1 = destination

  logic                     load_acc;
  logic                     second_half;
  step_kind_e               kind;
  logic [NSET-1:0][AW-1:0]  elem_q, frame_q;
  logic                     src_sel_q, dst_sel_q;
  logic [NSIDE-1:0]         side_sel;
  logic [NSIDE-1:0][AW-1:0] side_load, side_step, side_addr;

  assign load_acc = cfg_load && !xfer_done;
  assign kind     = pick_kind(last_elem, dword_mode, second_half);

  dma_idx_regfile #(.AW(AW), .NSET(NSET)) u_regs (
    .clk(clk), .rst_n(rst_n), .load_en(load_acc),
    .elem_in({cfg_elem_idx1, cfg_elem_idx0}),
    .frame_in({cfg_frame_idx1, cfg_frame_idx0}),
    .src_sel_in(cfg_src_sel), .dst_sel_in(cfg_dst_sel),
    .elem_q(elem_q), .frame_q(frame_q),
    .src_sel_q(src_sel_q), .dst_sel_q(dst_sel_q)
  );

  dma_dw_phase u_phase (
    .clk(clk), .rst_n(rst_n), .clear(load_acc),
    .dword_mode(dword_mode), .xfer_done(xfer_done),
    .second_half(second_half)
  );

  assign side_sel  = {dst_sel_q, src_sel_q};
  assign side_load = {cfg_dst_addr, cfg_src_addr};

  for (genvar i = 0; i < NSIDE; i++) begin : g_side
    dma_step_sel #(.AW(AW), .NSET(NSET)) u_step (
      .set_sel(side_sel[i]), .kind(kind),
      .elem_idx(elem_q), .frame_idx(frame_q), .step(side_step[i])
    );
    dma_addr_reg #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .load_en(load_acc), .load_val(side_load[i]),
      .adv(xfer_done), .step(side_step[i]), .addr(side_addr[i])
    );
  end

  assign src_addr = side_addr[0];
  assign dst_addr = side_addr[1];

  // R5
  frame_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && last_elem && !dword_mode) |=>
      (AW'(src_addr - $past(src_addr)) == $past(frame_q[src_sel_q])));
  // R7
  first_half_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && dword_mode && !second_half) |=>
      (AW'(dst_addr - $past(dst_addr)) == $past(elem_q[dst_sel_q])));
endmodule

// File: tb/sim_dma_index_agen.sv
`timescale 1ns/1ps
module sim_dma_index_agen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [15:0] cfg_src_addr = '0, cfg_dst_addr = '0;
  logic [15:0] cfg_elem_idx0 = '0, cfg_elem_idx1 = '0;
  logic [15:0] cfg_frame_idx0 = '0, cfg_frame_idx1 = '0;
  logic cfg_src_sel = 1'b0, cfg_dst_sel = 1'b0;
  logic xfer_done = 1'b0, last_elem = 1'b0, dword_mode = 1'b0;
  logic [15:0] src_addr, dst_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dma_index_agen u0 (.*);

  // {dword_mode, last_elem, expected src, expected dst}
  // config: src 1000, dst 2000, elem {2, -1}, frame {10h, -20h}, src set 0, dst set 1
  localparam logic [33:0] VEC [8] = '{
    {1'b0, 1'b0, 16'h1002, 16'h1FFF},  // R4
    {1'b0, 1'b0, 16'h1004, 16'h1FFE},  // R4
    {1'b0, 1'b1, 16'h1014, 16'h1FDE},  // R5
    {1'b0, 1'b0, 16'h1016, 16'h1FDD},  // R4
    {1'b1, 1'b1, 16'h1018, 16'h1FDC},  // R7 first half, last set
    {1'b1, 1'b1, 16'h1028, 16'h1FBC},  // R8 second half, last set
    {1'b1, 1'b0, 16'h102A, 16'h1FBB},  // R7
    {1'b1, 1'b0, 16'h102C, 16'h1FBA}   // R8 second half, not last
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_cfg(logic [15:0] s, logic [15:0] d, logic ssel, logic dsel);
    cfg_load = 1'b1; cfg_src_addr = s; cfg_dst_addr = d;
    cfg_elem_idx0 = 16'h0002; cfg_elem_idx1 = 16'hFFFF;
    cfg_frame_idx0 = 16'h0010; cfg_frame_idx1 = 16'hFFE0;
    cfg_src_sel = ssel; cfg_dst_sel = dsel;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic strobe(logic dw, logic last);
    xfer_done = 1'b1; dword_mode = dw; last_elem = last;
    @(negedge clk);
    xfer_done = 1'b0; last_elem = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 src", src_addr, 16'h0000);
    chk("R1 dst", dst_addr, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    load_cfg(16'h1000, 16'h2000, 1'b0, 1'b1);
    chk("R2 src load", src_addr, 16'h1000);
    chk("R2 dst load", dst_addr, 16'h2000);

    for (int i = 0; i < 8; i++) begin
      strobe(VEC[i][33], VEC[i][32]);
      chk("R4/R5/R7/R8 src vec", src_addr, VEC[i][31:16]);
      chk("R4/R5/R7/R8 dst vec", dst_addr, VEC[i][15:0]);
    end
    dword_mode = 1'b0;

    // R2 load ignored when a strobe arrives at the same edge
    cfg_load = 1'b1; cfg_src_addr = 16'h5555; cfg_dst_addr = 16'hAAAA;
    cfg_src_sel = 1'b1; cfg_dst_sel = 1'b0;
    strobe(1'b0, 1'b0);
    cfg_load = 1'b0;
    chk("R2 ignored src", src_addr, 16'h102E);
    chk("R2 ignored dst", dst_addr, 16'h1FB9);

    // R3 hold without strobe
    repeat (3) @(negedge clk);
    chk("R3 src hold", src_addr, 16'h102E);
    chk("R3 dst hold", dst_addr, 16'h1FB9);

    // R6 wrap and R10 swapped sets
    load_cfg(16'hFFFF, 16'h0000, 1'b1, 1'b0);
    strobe(1'b0, 1'b0);
    chk("R6 R10 src wrap elem", src_addr, 16'hFFFE);
    chk("R10 dst elem set0", dst_addr, 16'h0002);
    strobe(1'b0, 1'b1);
    chk("R6 R10 src frame set1", src_addr, 16'hFFDE);
    chk("R10 dst frame set0", dst_addr, 16'h0012);

    // R9 phase cleared by dword_mode low
    strobe(1'b1, 1'b0);
    chk("R7 src first half", src_addr, 16'hFFDD);
    dword_mode = 1'b0;
    @(negedge clk);
    strobe(1'b1, 1'b1);
    chk("R9 src after mode drop", src_addr, 16'hFFDC);
    chk("R9 dst after mode drop", dst_addr, 16'h0016);
    strobe(1'b1, 1'b1);
    chk("R8 src second half", src_addr, 16'hFFBC);
    chk("R8 dst second half", dst_addr, 16'h0026);

    // R9 phase cleared by an accepted load
    strobe(1'b1, 1'b0);
    load_cfg(16'h0100, 16'h0200, 1'b1, 1'b0);
    strobe(1'b1, 1'b1);
    chk("R9 src after load", src_addr, 16'h00FF);
    chk("R9 dst after load", dst_addr, 16'h0202);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule